// File: doc/BRIEF.md
# Platform Control and Status Register Window

This block is a small 32-bit register window that reports board-level status and build configuration to software and accepts one command: a request to reset the whole system. It sits behind a simple request/response port. A request carries an address, a write enable, write data and an access size. The block answers with read data and a ready strobe one cycle later.

Most of the registers are constants. Two registers are built from live inputs: the interrupt-timer frequency in MHz and the installed memory size in GiB. Writes to anything other than the soft-reset register are discarded. A qualifying write to the soft-reset register produces a single-cycle reset request on a dedicated output.

The block does not generate clocks, calibrate memory or sequence the reset. It only reports the status bits that those functions would present.

Top module: `plat_ctrl_regs`

## Requirements
- R1: `rsp_ready` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise. `rsp_rdata` is zero whenever `rsp_ready` is low.
- R2: Only word accesses (`req_size` = 2'b10; 2'b00 = byte, 2'b01 = half, 2'b11 = double) take effect. A read of any other size returns zero, and a write of any other size never raises `sys_reset_req`.
- R3: Word reads of offsets 0x000, 0x004 and 0x008 return zero.
- R4: A word read of offset 0x014 returns 0x00000005 (bit 0 locked, bit 2 calibrated, all else clear), whatever was written there before.
- R5: A word write to offset 0x010 with data bit 4 set drives `sys_reset_req` high for exactly the one cycle in which `rsp_ready` answers that write. The same write with bit 4 clear leaves the output low.
- R6: A word read of offset 0x030 returns `{8'd1, 8'd1, timer_mhz, 8'd1}`. Bits 31:24 are the second divider, bits 23:16 the multiplier, bits 15:8 the frequency, and bits 7:0 the first divider. The frequency is sampled in the request cycle.
- R7: A word read of offset 0x034 returns 0x0000000E: three link interfaces enabled in bits 3:1, and bit 0 clear.
- R8: A word read of offset 0x038 returns `mem_gib` in bits 3:0, ones in bits 15:4, and zero above.
- R9: Reads of every other offset, including 0x010, 0x018, unaligned offsets and the top of the 4 KiB window, return zero. Writes to any offset other than 0x010 change no read value and raise no reset request.
- R10: While `rst_n` is low, `rsp_ready`, `rsp_rdata` and `sys_reset_req` are all zero, even if a reset-register write is presented at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the 4 KiB window |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| req_wdata | input | 32 | Write data |
| timer_mhz | input | 8 | Interrupt-timer frequency in MHz |
| mem_gib | input | 4 | Installed memory size in GiB |
| rsp_rdata | output | 32 | Read data, valid with ready |
| rsp_ready | output | 1 | Response strobe, one cycle after a request |
| sys_reset_req | output | 1 | Single-cycle system reset request |

## Verification
The bench targets the places where a register window tends to leak.

- **Narrow accesses.** Narrow reads of non-zero registers are checked. A design that ignored the size field would return the status or divider value instead of zero.
- **Narrow and double-width reset writes.** Sub-word and double-width writes to the reset register are checked. A design that skipped the size check would fire a reset on them.
- **Writes to constant registers.** Writes to the constant registers are followed by read-backs. A design that accidentally stored write data would return the written value.
- **Decode edges.** Unaligned offsets, offset 0x010 on read, and the last word of the window are checked. These catch decoders that compare too few address bits or fall into a non-zero default.
- **Pulse timing.** The reset pulse is checked in its exact cycle and one cycle later. This exposes an output that sticks high or lands a cycle late.

// File: rtl/plat_pkg.sv
package plat_pkg;

  // Access size encoding on req_size
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_DBL  = 2'b11;

  localparam int DATA_W = 32;
  localparam int MHZ_W  = 8;
  localparam int GIB_W  = 4;

  // Offsets whose positions software depends on
  localparam logic [11:0] OFF_ID0     = 12'h000;
  localparam logic [11:0] OFF_ID1     = 12'h004;
  localparam logic [11:0] OFF_ID2     = 12'h008;
  localparam logic [11:0] OFF_SOFTRST = 12'h010;
  localparam logic [11:0] OFF_MEMSTAT = 12'h014;
  localparam logic [11:0] OFF_CLKDIV  = 12'h030;
  localparam logic [11:0] OFF_BUILD   = 12'h034;
  localparam logic [11:0] OFF_MEMCFG  = 12'h038;

  // Bit of the soft-reset register that requests a system reset
  localparam int RST_BIT = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IDZERO,
    SEL_SOFTRST,
    SEL_MEMSTAT,
    SEL_CLKDIV,
    SEL_BUILD,
    SEL_MEMCFG
  } reg_sel_e;

  // Memory status: locked (bit 0) and calibrated (bit 2)
  function automatic logic [DATA_W-1:0] memstat_word();
    logic [DATA_W-1:0] v;
    v = '0;
    v[0] = 1'b1;
    v[2] = 1'b1;
    return v;
  endfunction

  // Build configuration: three link interfaces enabled, coherency unit off
  function automatic logic [DATA_W-1:0] build_word();
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 1; i <= 3; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Clock divider word: second divider, multiplier, frequency, first divider
  function automatic logic [DATA_W-1:0] clkdiv_word(input logic [MHZ_W-1:0] mhz);
    return {8'd1, 8'd1, mhz, 8'd1};
  endfunction

  // Memory configuration: size in GiB low, speed field all ones
  function automatic logic [DATA_W-1:0] memcfg_word(input logic [GIB_W-1:0] gib);
    return {16'h0000, 12'hFFF, gib};
  endfunction

endpackage

// File: rtl/plat_decode.sv
module plat_decode
  import plat_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rd_word,
  output logic              wr_word,
  output reg_sel_e          sel
);

  logic is_word;
  assign is_word = (req_size == SZ_WORD);
  assign rd_word = req_valid && !req_we && is_word;
  assign wr_word = req_valid &&  req_we && is_word;

  always_comb begin
    unique case (req_addr)
      OFF_ID0, OFF_ID1, OFF_ID2: sel = SEL_IDZERO;
      OFF_SOFTRST:               sel = SEL_SOFTRST;
      OFF_MEMSTAT:               sel = SEL_MEMSTAT;
      OFF_CLKDIV:                sel = SEL_CLKDIV;
      OFF_BUILD:                 sel = SEL_BUILD;
      OFF_MEMCFG:                sel = SEL_MEMCFG;
      default:                   sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/plat_rdmux.sv
module plat_rdmux
  import plat_pkg::*;
(
  input  reg_sel_e          sel,
  input  logic              rd_word,
  input  logic [MHZ_W-1:0]  timer_mhz,
  input  logic [GIB_W-1:0]  mem_gib,
  output logic [DATA_W-1:0] rd_value
);

  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (sel)
      SEL_MEMSTAT: raw = memstat_word();
      SEL_CLKDIV:  raw = clkdiv_word(timer_mhz);
      SEL_BUILD:   raw = build_word();
      SEL_MEMCFG:  raw = memcfg_word(mem_gib);
      default:     raw = '0;
    endcase
  end

  assign rd_value = rd_word ? raw : '0;

endmodule

// File: rtl/plat_rstreq.sv
module plat_rstreq
  import plat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_word,
  input  reg_sel_e sel,
  input  logic     cmd_bit,
  output logic     sys_reset_req
);

  logic fire;
  assign fire = wr_word && (sel == SEL_SOFTRST) && cmd_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_reset_req <= 1'b0;
    else        sys_reset_req <= fire;
  end

  // R5
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr_word && sel == SEL_SOFTRST && cmd_bit));

  // R5
  pulse_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word && sel == SEL_SOFTRST && cmd_bit) |=> sys_reset_req);

endmodule

// File: rtl/plat_ctrl_regs.sv
module plat_ctrl_regs
  import plat_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [7:0]        timer_mhz,
  input  logic [3:0]        mem_gib,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_ready,
  output logic              sys_reset_req
);

  logic              rd_word;
  logic              wr_word;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_value;
  logic              unused_wdata;

  assign unused_wdata = ^{req_wdata[DATA_W-1:RST_BIT+1], req_wdata[RST_BIT-1:0]};

  plat_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rd_word   (rd_word),
    .wr_word   (wr_word),
    .sel       (sel)
  );

  plat_rdmux u_rdmux (
    .sel       (sel),
    .rd_word   (rd_word),
    .timer_mhz (timer_mhz),
    .mem_gib   (mem_gib),
    .rd_value  (rd_value)
  );

  plat_rstreq u_rstreq (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_word       (wr_word),
    .sel           (sel),
    .cmd_bit       (req_wdata[RST_BIT]),
    .sys_reset_req (sys_reset_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_rdata <= req_valid ? rd_value : '0;
    end
  end

  // R1
  ready_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);

  // R1
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> rsp_rdata == '0);

  // R2
  narrow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_size != SZ_WORD) |=> rsp_rdata == '0);

  // R2
  narrow_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != SZ_WORD) |=> !sys_reset_req);

  // R4
  memstat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_size == SZ_WORD && req_addr == OFF_MEMSTAT)
      |=> rsp_rdata == 32'h0000_0005);

  // R5
  pulse_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> rsp_ready);

endmodule

// File: tb/plat_ctrl_regs_tb.sv
module plat_ctrl_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic [7:0]  timer_mhz = 8'd50;
  logic [3:0]  mem_gib = 4'd2;
  logic [31:0] rsp_rdata;
  logic        rsp_ready;
  logic        sys_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plat_ctrl_regs u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .timer_mhz     (timer_mhz),
    .mem_gib       (mem_gib),
    .rsp_rdata     (rsp_rdata),
    .rsp_ready     (rsp_ready),
    .sys_reset_req (sys_reset_req)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        rst;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  // timer_mhz = 50 (0x32), mem_gib = 2 for the table
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 12'h000, 32'h0, 32'h0000_0000, 1'b0, 8'd3},       // R3
    '{1'b0, 2'd2, 12'h004, 32'h0, 32'h0000_0000, 1'b0, 8'd3},       // R3
    '{1'b0, 2'd2, 12'h008, 32'h0, 32'h0000_0000, 1'b0, 8'd3},       // R3
    '{1'b0, 2'd2, 12'h014, 32'h0, 32'h0000_0005, 1'b0, 8'd4},       // R4
    '{1'b0, 2'd2, 12'h030, 32'h0, 32'h0101_3201, 1'b0, 8'd6},       // R6
    '{1'b0, 2'd2, 12'h034, 32'h0, 32'h0000_000E, 1'b0, 8'd7},       // R7
    '{1'b0, 2'd2, 12'h038, 32'h0, 32'h0000_FFF2, 1'b0, 8'd8},       // R8
    '{1'b0, 2'd2, 12'h018, 32'h0, 32'h0000_0000, 1'b0, 8'd9},       // R9
    '{1'b0, 2'd2, 12'h010, 32'h0, 32'h0000_0000, 1'b0, 8'd9},       // R9
    '{1'b0, 2'd0, 12'h014, 32'h0, 32'h0000_0000, 1'b0, 8'd2},       // R2
    '{1'b0, 2'd1, 12'h030, 32'h0, 32'h0000_0000, 1'b0, 8'd2},       // R2
    '{1'b1, 2'd2, 12'h010, 32'h0000_0010, 32'h0, 1'b1, 8'd5},       // R5
    '{1'b1, 2'd2, 12'h010, 32'hFFFF_FFEF, 32'h0, 1'b0, 8'd5},       // R5
    '{1'b1, 2'd0, 12'h010, 32'h0000_0010, 32'h0, 1'b0, 8'd2},       // R2
    '{1'b1, 2'd2, 12'h014, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd9},       // R9
    '{1'b0, 2'd2, 12'h014, 32'h0, 32'h0000_0005, 1'b0, 8'd4},       // R4
    '{1'b1, 2'd2, 12'h038, 32'h0000_0000, 32'h0, 1'b0, 8'd9},       // R9
    '{1'b0, 2'd2, 12'h038, 32'h0, 32'h0000_FFF2, 1'b0, 8'd8},       // R8
    '{1'b0, 2'd2, 12'hFFC, 32'h0, 32'h0000_0000, 1'b0, 8'd9},       // R9
    '{1'b0, 2'd2, 12'h015, 32'h0, 32'h0000_0000, 1'b0, 8'd9},       // R9
    '{1'b1, 2'd2, 12'h030, 32'h0000_0000, 32'h0, 1'b0, 8'd9},       // R9
    '{1'b0, 2'd2, 12'h030, 32'h0, 32'h0101_3201, 1'b0, 8'd6},       // R6
    '{1'b1, 2'd3, 12'h010, 32'h0000_0010, 32'h0, 1'b0, 8'd2}        // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Issue one request at a negedge; sample the response one clock later
  task automatic xact(input logic we, input logic [1:0] sz, input logic [11:0] addr,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic rdy, output logic rq);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; rdy = rsp_ready; rq = sys_reset_req;
    req_valid = 1'b0; req_we = 1'b0; req_wdata = '0;
  endtask

  initial begin
    logic [31:0] rd;
    logic rdy, rq;

    // R10: reset state
    #3;
    check("R10 ready in reset", {31'b0, rsp_ready}, 32'h0);
    check("R10 rdata in reset", rsp_rdata, 32'h0);
    check("R10 reset_req in reset", {31'b0, sys_reset_req}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle ready low", {31'b0, rsp_ready}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xact(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].wd, rd, rdy, rq);
      check($sformatf("R1 ready vec %0d", i), {31'b0, rdy}, 32'h1);
      check($sformatf("R%0d rdata vec %0d", VECS[i].req, i), rd, VECS[i].exp);
      check($sformatf("R%0d reset_req vec %0d", VECS[i].req, i), {31'b0, rq}, {31'b0, VECS[i].rst});
      @(negedge clk);
      check($sformatf("R1 ready drops vec %0d", i), {31'b0, rsp_ready}, 32'h0);
      check($sformatf("R5 pulse one cycle vec %0d", i), {31'b0, sys_reset_req}, 32'h0);
      check($sformatf("R1 rdata idle vec %0d", i), rsp_rdata, 32'h0);
    end

    // R6 / R8: live inputs at other values
    timer_mhz = 8'd200;
    mem_gib = 4'd1;
    xact(1'b0, 2'b10, 12'h030, 32'h0, rd, rdy, rq);
    check("R6 clkdiv at 200 MHz", rd, 32'h0101_C801);
    xact(1'b0, 2'b10, 12'h038, 32'h0, rd, rdy, rq);
    check("R8 memcfg at 1 GiB", rd, 32'h0000_FFF1);
    timer_mhz = 8'hFF;
    mem_gib = 4'hF;
    xact(1'b0, 2'b10, 12'h030, 32'h0, rd, rdy, rq);
    check("R6 clkdiv at max", rd, 32'h0101_FF01);
    xact(1'b0, 2'b10, 12'h038, 32'h0, rd, rdy, rq);
    check("R8 memcfg at max", rd, 32'h0000_FFFF);

    // R10: reset asserted while a reset-register write is presented
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_size = 2'b10; req_addr = 12'h010;
    req_wdata = 32'h10;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 no pulse under reset", {31'b0, sys_reset_req}, 32'h0);
    check("R10 no ready under reset", {31'b0, rsp_ready}, 32'h0);
    req_valid = 1'b0; req_we = 1'b0; req_wdata = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 quiet after release", {31'b0, sys_reset_req}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule